// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block produces the stream of element byte addresses for a single vector load or store. A start pulse latches a base address, an addressing mode, a scalar step, an element size, a requested element count and a per-element enable mask. The block then offers one address per cycle on a valid/ready port toward a memory pipeline. Each address carries an enable bit that tells the memory side whether to actually move the element.

Four addressing modes are supported:

- **Contiguous:** the step is the element size.
- **Programmable step:** a scalar register supplies the step.
- **Gather/scatter:** each element's offset comes from an index stream with its own valid/ready pair.
- **Index ramp:** emits the values 0, m, 2m, … so that an index vector can be built from a scalar m.

The element count is capped at the register capacity. An oversize request is trimmed to that capacity and sets a sticky error flag. Masked-off elements still take their slot in the stream. A one-cycle done pulse marks the end of the operation. A zero-length operation produces done without issuing any address.

Top module: `vec_addr_seq`

## Requirements
- R1: Mode code 2'b00 (contiguous): element i is issued at base + i × (1 << esz), where esz 0..3 selects 1, 2, 4 or 8 bytes; all addresses wrap modulo 2^ADDR_W.
- R2: Mode code 2'b01 (programmable step): element i is issued at base + i × stride, with stride taken as an ADDR_W-bit two's-complement value, so a negative step counts down.
- R3: Mode code 2'b10 (gather/scatter): element i is issued at base + idx_data, where idx_data is the i-th value accepted on the index stream. No address is offered while idx_valid is low. idx_ready is high exactly in the cycles in which an element is handed over in this mode.
- R4: Mode code 2'b11 (index ramp): element i is issued as i × stride, and base is not used.
- R5: The number of address handshakes in one operation equals the smaller of vlen_req and MAX_LEN.
- R6: When vlen_req is greater than MAX_LEN, the operation runs for MAX_LEN elements and len_err rises; len_err then stays high until reset.
- R7: addr_en for element i equals bit i of the mask sampled at start. An element whose bit is 0 is still issued and still takes a handshake.
- R8: While addr_valid is high and addr_ready is low, the next cycle shows the same addr and addr_en.
- R9: done is high for one cycle, in the cycle after the last element handshake. A zero-length request raises done in the cycle after start, with no address issued.
- R10: A start pulse while an operation is in progress is ignored, and no address is offered outside an operation.
- R11: After reset addr_valid, busy, done and len_err are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| mode | input | 2 | Addressing mode code (see R1–R4) |
| base | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Scalar step for programmable-step and ramp modes |
| esz | input | 2 | log2 of element size in bytes |
| vlen_req | input | REQ_W | Requested element count |
| mask | input | MAX_LEN | Per-element enable bits, bit i for element i |
| idx_valid | input | 1 | Index stream value present |
| idx_data | input | ADDR_W | Index stream byte offset |
| idx_ready | output | 1 | Index value consumed this cycle |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Memory side takes the address |
| addr | output | ADDR_W | Element byte address |
| addr_en | output | 1 | Element enable from the mask |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| len_err | output | 1 | Sticky oversize-length flag |

## Verification
The bench goes after the following corner cases:

- **Back-pressure from memory.** A sequencer that advanced its accumulator on a stalled cycle would skip an element and show an address mismatch at the next handshake.
- **Gaps in the index stream.** A sequencer that ignored idx_valid would issue base plus a stale index.
- **Length edges.** Lengths of zero, exactly MAX_LEN and above MAX_LEN are run. An unclamped counter would run past the mask or never finish, and a zero-length case handled like any other would emit a stray address or no done at all.
- **Start while busy.** This would reload the base mid-stream and show up as unexpected addresses.
- **Negative step and the index ramp.** These catch sign handling and a ramp that wrongly adds the base.

// File: rtl/vec_addr_seq.sv
module vec_addr_seq #(
  parameter int ADDR_W  = 32,
  parameter int MAX_LEN = 64,
  parameter int REQ_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [1:0]        esz,
  input  logic [REQ_W-1:0]  vlen_req,
  input  logic [MAX_LEN-1:0] mask,
  input  logic              idx_valid,
  input  logic [ADDR_W-1:0] idx_data,
  output logic              idx_ready,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_en,
  output logic              busy,
  output logic              done,
  output logic              len_err
);

  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam int SEL_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [1:0] M_UNIT = 2'b00;
  localparam logic [1:0] M_STEP = 2'b01;
  localparam logic [1:0] M_IDX  = 2'b10;
  localparam logic [1:0] M_RAMP = 2'b11;

  logic [1:0]         mode_q;
  logic [ADDR_W-1:0]  base_q, step_q, acc;
  logic [CNT_W-1:0]   cnt, len_q;
  logic [MAX_LEN-1:0] mask_q;
  logic               done_q, err_q;

  logic               over, accept, fire, last;
  logic [CNT_W-1:0]   len_new, cnt_nxt;
  logic [ADDR_W-1:0]  step_new;

  assign over     = vlen_req > REQ_W'(MAX_LEN);
  assign len_new  = over ? CNT_W'(MAX_LEN) : vlen_req[CNT_W-1:0];
  assign step_new = (mode == M_UNIT) ? (ADDR_W'(1) << esz) : stride;
  assign accept   = start & ~busy;

  assign addr_valid = busy & ((mode_q != M_IDX) | idx_valid);
  assign fire       = addr_valid & addr_ready;
  assign idx_ready  = fire & (mode_q == M_IDX);
  assign addr       = (mode_q == M_IDX) ? base_q + idx_data : acc;
  assign addr_en    = mask_q[cnt[SEL_W-1:0]];
  assign cnt_nxt    = cnt + 1'b1;
  assign last       = cnt_nxt == len_q;
  assign done       = done_q;
  assign len_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= M_UNIT;
      base_q <= '0;
      step_q <= '0;
      acc    <= '0;
      cnt    <= '0;
      len_q  <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        mode_q <= mode;
        base_q <= base;
        step_q <= step_new;
        acc    <= (mode == M_RAMP) ? '0 : base;
        cnt    <= '0;
        len_q  <= len_new;
        mask_q <= mask;
        busy   <= len_new != '0;
        done_q <= len_new == '0;
        if (over) err_q <= 1'b1;
      end else if (fire) begin
        cnt <= cnt_nxt;
        acc <= acc + step_q;
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready && mode_q != M_IDX |=> addr_valid && $stable(addr) && $stable(addr_en));

  p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last && mode_q != M_IDX |=> addr == $past(addr) + step_q);

  p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> len_q <= CNT_W'(MAX_LEN) && cnt < len_q);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !addr_valid);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base_q) && $stable(mode_q) && $stable(len_q));

  p_idx_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == M_IDX && !idx_valid |-> !idx_ready);

endmodule

// File: tb/vec_addr_seq_bench.sv
`timescale 1ns/1ps
module vec_addr_seq_bench;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [1:0]  mode = 0, esz = 0;
  logic [31:0] base = 0, stride = 0, idx_data = 0, addr;
  logic [7:0]  vlen_req = 0;
  logic [63:0] mask = 0;
  logic idx_valid = 0, idx_ready, addr_valid, addr_ready = 0, addr_en, busy, done, len_err;

  vec_addr_seq u_vec_addr_seq (.clk, .rst_n, .start, .mode, .base, .stride, .esz, .vlen_req,
    .mask, .idx_valid, .idx_data, .idx_ready, .addr_valid, .addr_ready, .addr, .addr_en,
    .busy, .done, .len_err);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [32:0] q[$];
  logic [31:0] idx_list[64];
  int idx_ptr = 0, fire_cnt = 0, exp_n = 0;
  bit model_busy = 0, exp_done = 0, op_done = 0, held = 0;
  logic [32:0] held_v;
  logic [1:0] cur_mode = 0;
  bit rdy_rand = 0, idx_rand = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    addr_ready <= rdy_rand ? (lfsr[0] | lfsr[4]) : 1'b1;
    idx_valid  <= idx_rand ? (lfsr[2] | lfsr[7]) : 1'b1;
    idx_data   <= idx_list[idx_ptr & 63];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete(); model_busy = 0; exp_done = 0; held = 0;
    end else begin
      bit acc, fire;
      int n;
      logic [32:0] e;
      acc  = start && !model_busy;
      fire = addr_valid && addr_ready;
      if (exp_done || done) check(done === exp_done, "R9", "done pulse", done, exp_done);
      if (done) begin
        op_done = 1;
        check(fire_cnt == exp_n, "R5", "handshake count", fire_cnt, exp_n);
      end
      exp_done = 0;
      if (addr_valid && !model_busy) check(0, "R10", "address outside operation", addr, 0);
      if (held && addr_valid && model_busy)
        check({addr_en, addr} === held_v, "R8", "stalled address changed", addr, held_v[31:0]);
      held = addr_valid && !addr_ready && model_busy;
      held_v = {addr_en, addr};
      if (model_busy) check(idx_ready === (fire && cur_mode == 2'b10), "R3", "idx_ready", idx_ready, fire && cur_mode == 2'b10);
      if (fire && model_busy) begin
        e = q.pop_front();
        check(addr === e[31:0], mode_tag(cur_mode), "element address", addr, e[31:0]);
        check(addr_en === e[32], "R7", "element enable", addr_en, e[32]);
        fire_cnt++;
        if (cur_mode == 2'b10) idx_ptr++;
        if (q.size() == 0) begin model_busy = 0; exp_done = 1; end
      end
      if (acc) begin
        n = (vlen_req > 64) ? 64 : vlen_req;
        exp_n = n; fire_cnt = 0; idx_ptr = 0; cur_mode = mode;
        for (int i = 0; i < n; i++) begin
          logic [31:0] a;
          case (mode)
            2'b00: a = base + (32'(i) << esz);
            2'b01: a = base + 32'(i) * stride;
            2'b10: a = base + idx_list[i];
            default: a = 32'(i) * stride;
          endcase
          q.push_back({mask[i], a});
        end
        if (n == 0) exp_done = 1; else model_busy = 1;
      end
    end
  end

  task automatic pulse(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                       input logic [1:0] z, input int len, input logic [63:0] mk);
    @(posedge clk); #1;
    start = 1; mode = m; base = b; stride = s; esz = z; vlen_req = 8'(len); mask = mk;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic run(input logic [1:0] m, input logic [31:0] b, input logic [31:0] s,
                     input logic [1:0] z, input int len, input logic [63:0] mk);
    op_done = 0;
    pulse(m, b, s, z, len, mk);
    while (!op_done) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) idx_list[i] = 32'(i * 37 + 5) ^ 32'h100;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(addr_valid === 0, "R11", "reset addr_valid", addr_valid, 0);
    check(busy === 0, "R11", "reset busy", busy, 0);
    check(done === 0, "R11", "reset done", done, 0);
    check(len_err === 0, "R11", "reset len_err", len_err, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    run(2'b00, 32'h1000, 0, 2'd3, 5, '1);                            // R1 8-byte
    rdy_rand = 1;
    run(2'b00, 32'hFFFF_FFFC, 0, 2'd0, 9, 64'h1F5);                  // R1 R8 byte, wrap
    run(2'b01, 32'h2000, 32'h30, 2'd2, 6, 64'h2A);                   // R2 R7
    rdy_rand = 0;
    run(2'b01, 32'h40, 32'hFFFF_FFF0, 2'd2, 3, 64'h5);               // R2 negative step
    idx_rand = 1; rdy_rand = 1;
    run(2'b10, 32'h8000, 0, 2'd2, 12, 64'hF0F);                      // R3
    idx_rand = 0; rdy_rand = 0;
    run(2'b11, 32'hDEAD_0000, 32'd7, 2'd0, 64, '1);                  // R4 full length
    @(negedge clk);
    check(len_err === 0, "R6", "no error at exactly MAX_LEN", len_err, 0);
    rdy_rand = 1;
    run(2'b00, 32'h3000, 0, 2'd2, 70, 64'h8000_0000_0000_0001);      // R6 clamp
    rdy_rand = 0;
    @(negedge clk);
    check(len_err === 1, "R6", "len_err after oversize", len_err, 1);
    run(2'b01, 32'h5000, 32'h4, 2'd2, 0, '1);                        // R9 zero length
    check(addr_valid === 0, "R9", "no address for zero length", addr_valid, 0);
    op_done = 0;
    pulse(2'b01, 32'h6000, 32'h10, 2'd2, 6, '1);                     // R10
    pulse(2'b00, 32'hBEEF_0000, 0, 2'd0, 3, '0);
    while (!op_done) @(negedge clk);
    repeat (3) @(negedge clk);
    check(addr_valid === 0, "R10", "ignored start issued nothing", addr_valid, 0);
    check(len_err === 1, "R6", "len_err still set", len_err, 1);
    finish_up();
  end
endmodule